// File: doc/BRIEF.md
# Flash Reset and Sleep Controller

This block is the control front end of a cycle-based model of a NOR-style flash memory. It watches an active-low hardware reset pin, the bus strobes (chip enable, output enable, write enable) and the address bus. From these it decides when reads and writes reach the array, when the data pins are driven, and when the output data is frozen because the device has fallen into its automatic low-power state. It also has a handshake with the embedded program/erase engine. It reads that engine's busy flag, and on a qualified reset it sends the engine a one-cycle abort.

A reset counts only if the pin stays low for a minimum number of samples. A qualified reset pulls the ready flag low for a recovery time. That time is longer when an embedded operation was running at the moment of qualification than when the device was idle. After the pin returns high, bus accesses stay blocked for a further window. The low-power state does not look at the bus strobes. It follows only the address: after a fixed number of cycles with an unchanged address, the output data is held, and any address change ends the hold. All timing is in clock cycles set by parameters. Every output is a register, so each output follows its inputs by one clock edge.

Top module: `flash_rst_sleep_ctrl`

## Requirements
- R1: A low pulse on `rst_n_pin` that is sampled low on fewer than T_RP consecutive edges is ignored. It raises no `eng_abort`, and it changes neither `ready` nor the access gating once the pin is high again.
- R2: A reset is qualified on the edge that samples the pin low for the T_RP-th consecutive time. `eng_abort` is 1 for exactly the one cycle after that edge and is 0 otherwise.
- R3: On every edge that samples `rst_n_pin` low, `dout_oe` and `wr_en` are registered to 0, so the data pins are tristated and writes are dropped from the next cycle on.
- R4: If `eng_busy` is 1 on the qualifying edge, `ready` (1 = ready, 0 = busy) reads 0 for T_RDY_BUSY+1 cycles after that edge and then 1, provided the engine is idle by then.
- R5: If `eng_busy` is 0 on the qualifying edge, `ready` reads 0 for T_RDY_IDLE+1 cycles after that edge and then 1.
- R6: After a qualified reset, the edge that first samples the pin high is h. Reads (`ce_n`=0, `oe_n`=0, `we_n`=1) and writes (`ce_n`=0, `we_n`=0) stay blocked on edges h through h+T_RH-1 and are accepted again from edge h+T_RH. The device then accepts reads in its array state, and no aborted operation resumes.
- R7: `dout_oe` is 0 in the cycle after any edge that samples `oe_n` or `ce_n` high.
- R8: `dout_hold` rises after T_ACC+T_MARGIN consecutive edges that see the address unchanged, whatever `ce_n`, `oe_n` and `we_n` do. It stays 1 while the address stays unchanged.
- R9: An edge that sees a new address clears `dout_hold` in the next cycle, and a read in progress keeps `dout_oe` at 1 both during the hold and across the exit.
- R10: Outside reset recovery, `ready` is the inverse of `eng_busy`, delayed by one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| rst_n_pin | input | 1 | Hardware reset pin of the memory, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Address bus |
| eng_busy | input | 1 | Embedded program/erase engine is running |
| eng_abort | output | 1 | One-cycle abort request to the engine |
| ready | output | 1 | Ready/busy flag, 1 = ready |
| dout_oe | output | 1 | Drive enable of the data pins, 0 = high impedance |
| dout_hold | output | 1 | Low-power state: output data latched |
| wr_en | output | 1 | Write cycle accepted toward the command logic |

## Verification
The reset pin is driven with a pulse one sample short of qualification and with long pulses that begin while the engine is busy and while it is idle. Comparing these separates ignored glitches from real resets, and separates the long recovery from the short one, cycle by cycle on `ready` and `eng_abort`. A read and then a write are held through the release of the pin, which pins down the exact edge where the access window reopens. The sleep test holds one address while it toggles the bus strobes, then changes the address. This shows that entry and exit follow the address alone, while the data pins stay driven.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
  } bus_req_t;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/flash_rst_qual.sv
module flash_rst_qual #(
  parameter int unsigned T_RP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_low,
  output logic valid
);
  import flash_fe_pkg::*;
  localparam int unsigned CW = cnt_w(T_RP);

  logic [CW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      lo_cnt <= '0;
    else if (!pin_low)
      lo_cnt <= '0;
    else if (lo_cnt != CW'(T_RP))
      lo_cnt <= lo_cnt + 1'b1;
  end

  assign valid = pin_low && (lo_cnt == CW'(T_RP - 1));

  // one qualification per low pulse
  assert_valid_once_R2: assert property (@(posedge clk) disable iff (rst)
    (lo_cnt == CW'(T_RP)) |-> !valid);
  assert_count_after_valid_R1: assert property (@(posedge clk) disable iff (rst)
    valid |=> (lo_cnt == CW'(T_RP)));

endmodule

// File: rtl/flash_rst_recov.sv
module flash_rst_recov #(
  parameter int unsigned T_RDY_BUSY = 12,
  parameter int unsigned T_RDY_IDLE = 2,
  parameter int unsigned T_RH       = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_low,
  input  logic valid,
  input  logic eng_busy,
  output logic ready,
  output logic abort,
  output logic access_ok
);
  import flash_fe_pkg::*;
  localparam int unsigned T_MAX = (T_RDY_BUSY > T_RDY_IDLE) ? T_RDY_BUSY : T_RDY_IDLE;
  localparam int unsigned RCW   = cnt_w(T_MAX);
  localparam int unsigned HCW   = cnt_w(T_RH);

  logic [RCW-1:0] rec_cnt;
  logic [HCW-1:0] rh_cnt;
  logic           in_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_cnt <= '0;
      rh_cnt  <= '0;
      in_rst  <= 1'b0;
      ready   <= 1'b1;
      abort   <= 1'b0;
    end else begin
      abort <= valid;
      if (valid)
        rec_cnt <= eng_busy ? RCW'(T_RDY_BUSY) : RCW'(T_RDY_IDLE);
      else if (rec_cnt != '0)
        rec_cnt <= rec_cnt - 1'b1;
      if (valid)
        in_rst <= 1'b1;
      else if (!pin_low)
        in_rst <= 1'b0;
      if (valid || (in_rst && pin_low))
        rh_cnt <= HCW'(T_RH);
      else if (rh_cnt != '0)
        rh_cnt <= rh_cnt - 1'b1;
      ready <= !valid && (rec_cnt == '0) && !eng_busy;
    end
  end

  assign access_ok = !pin_low && (rec_cnt == '0) && (rh_cnt == '0);

  assert_abort_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    abort |=> !abort);
  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (rec_cnt != '0) |=> !ready);
  assert_abort_busy_R5: assert property (@(posedge clk) disable iff (rst)
    abort |-> !ready);
  assert_ready_follow_R10: assert property (@(posedge clk) disable iff (rst)
    eng_busy |=> !ready);
  assert_window_R6: assert property (@(posedge clk) disable iff (rst)
    (in_rst && pin_low) |=> !access_ok);

endmodule

// File: rtl/flash_sleep_det.sv
module flash_sleep_det #(
  parameter int unsigned AW      = 8,
  parameter int unsigned T_SLEEP = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  output logic          sleep
);
  import flash_fe_pkg::*;
  localparam int unsigned SCW = cnt_w(T_SLEEP);

  logic [AW-1:0]  addr_q;
  logic [SCW-1:0] st_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      st_cnt <= '0;
      sleep  <= 1'b0;
    end else if (addr != addr_q) begin
      addr_q <= addr;
      st_cnt <= '0;
      sleep  <= 1'b0;
    end else begin
      if (st_cnt != SCW'(T_SLEEP))
        st_cnt <= st_cnt + 1'b1;
      sleep <= (st_cnt >= SCW'(T_SLEEP - 1));
    end
  end

  assert_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (addr != addr_q) |=> !sleep);
  assert_stay_R8: assert property (@(posedge clk) disable iff (rst)
    (sleep && (addr == addr_q)) |=> sleep);

endmodule

// File: rtl/flash_rst_sleep_ctrl.sv
module flash_rst_sleep_ctrl #(
  parameter int unsigned AW         = 8,
  parameter int unsigned T_RP       = 4,
  parameter int unsigned T_RDY_BUSY = 12,
  parameter int unsigned T_RDY_IDLE = 2,
  parameter int unsigned T_RH       = 5,
  parameter int unsigned T_ACC      = 6,
  parameter int unsigned T_MARGIN   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rst_n_pin,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          eng_busy,
  output logic          eng_abort,
  output logic          ready,
  output logic          dout_oe,
  output logic          dout_hold,
  output logic          wr_en
);
  import flash_fe_pkg::*;
  localparam int unsigned T_SLEEP = T_ACC + T_MARGIN;

  logic     pin_low;
  logic     valid;
  logic     access_ok;
  bus_req_t req;

  assign pin_low = !rst_n_pin;
  assign req.rd  = !ce_n && !oe_n && we_n;
  assign req.wr  = !ce_n && !we_n;

  flash_rst_qual #(.T_RP(T_RP)) u_qual (
    .clk(clk), .rst(rst), .pin_low(pin_low), .valid(valid)
  );

  flash_rst_recov #(
    .T_RDY_BUSY(T_RDY_BUSY), .T_RDY_IDLE(T_RDY_IDLE), .T_RH(T_RH)
  ) u_recov (
    .clk(clk), .rst(rst), .pin_low(pin_low), .valid(valid),
    .eng_busy(eng_busy), .ready(ready), .abort(eng_abort),
    .access_ok(access_ok)
  );

  flash_sleep_det #(.AW(AW), .T_SLEEP(T_SLEEP)) u_sleep (
    .clk(clk), .rst(rst), .addr(addr), .sleep(dout_hold)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_oe <= 1'b0;
      wr_en   <= 1'b0;
    end else begin
      dout_oe <= req.rd && access_ok;
      wr_en   <= req.wr && access_ok;
    end
  end

  assert_tristate_R3: assert property (@(posedge clk) disable iff (rst)
    !rst_n_pin |=> (!dout_oe && !wr_en));
  assert_oe_off_R7: assert property (@(posedge clk) disable iff (rst)
    (oe_n || ce_n) |=> !dout_oe);

endmodule

// File: tb/sim_flash_rst_sleep_ctrl.sv
module sim_flash_rst_sleep_ctrl;
  localparam int AW = 8, TRP = 4, TB = 12, TI = 2, TRH = 5, TS = 9;

  logic clk = 1'b0, rst = 1'b1;
  logic rst_n_pin = 1'b1, ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b1, eng_busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic eng_abort, ready, dout_oe, dout_hold, wr_en;

  always #2.5 clk = ~clk;

  flash_rst_sleep_ctrl #(.AW(AW), .T_RP(TRP), .T_RDY_BUSY(TB), .T_RDY_IDLE(TI),
    .T_RH(TRH), .T_ACC(6), .T_MARGIN(3)) u0 (
    .clk(clk), .rst(rst), .rst_n_pin(rst_n_pin), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .eng_busy(eng_busy), .eng_abort(eng_abort),
    .ready(ready), .dout_oe(dout_oe), .dout_hold(dout_hold), .wr_en(wr_en));

  typedef struct { int cyc; int sig; logic val; string req; } exp_t;
  exp_t exp_q[$];
  int cyc = 0, n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  string sname[5] = '{"ready", "eng_abort", "dout_oe", "dout_hold", "wr_en"};

  always @(posedge clk) cyc++;

  function automatic logic sig_val(input int s);
    case (s)
      0: return ready;
      1: return eng_abort;
      2: return dout_oe;
      3: return dout_hold;
      default: return wr_en;
    endcase
  endfunction

  task automatic expect_at(input int c, input int s, input logic v, input string r);
    exp_t e;
    e.cyc = c; e.sig = s; e.val = v; e.req = r;
    exp_q.push_back(e);
  endtask

  // monitor: compares every queued item whose cycle has come
  always @(negedge clk) begin
    for (int i = exp_q.size() - 1; i >= 0; i--) begin
      if (exp_q[i].cyc == cyc) begin
        n_cmp++;
        if (sig_val(exp_q[i].sig) !== exp_q[i].val) begin
          n_bad++;
          $display("FAIL %s %s cyc=%0d actual=%b expected=%b", exp_q[i].req,
                   sname[exp_q[i].sig], cyc, sig_val(exp_q[i].sig), exp_q[i].val);
        end
        exp_q.delete(i);
      end
    end
  end

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  // hold the pin low for 'samples' edges; the engine drops busy when aborted
  task automatic pulse_pin(input int samples);
    int a;
    a = cyc + 1;
    rst_n_pin = 1'b0;
    while (cyc < a + samples - 1) begin
      @(negedge clk);
      if (eng_abort) eng_busy = 1'b0;
    end
    rst_n_pin = 1'b1;
  endtask

  initial begin
    int a, v, h, c;
    tick(3);
    rst = 1'b0;
    expect_at(cyc + 1, 0, 1'b1, "R10 reset");
    expect_at(cyc + 1, 1, 1'b0, "R2 reset");
    expect_at(cyc + 1, 2, 1'b0, "R7 reset");
    expect_at(cyc + 1, 4, 1'b0, "R3 reset");
    tick(2);
    // plain read, then output enable released
    oe_n = 1'b0;
    expect_at(cyc + 1, 2, 1'b1, "R6 read");
    tick(1);
    oe_n = 1'b1;
    expect_at(cyc + 1, 2, 1'b0, "R7");
    tick(1);
    ce_n = 1'b1; oe_n = 1'b0;
    expect_at(cyc + 1, 2, 1'b0, "R7 ce");
    tick(1);
    ce_n = 1'b0;
    // ready follows engine
    eng_busy = 1'b1;
    expect_at(cyc + 1, 0, 1'b0, "R10");
    tick(2);
    // short pulse while busy, read active
    a = cyc + 1;
    for (int i = 0; i <= TRP; i++) expect_at(a + i, 1, 1'b0, "R1");
    expect_at(a, 2, 1'b0, "R3");
    expect_at(a + TRP - 1, 2, 1'b1, "R1 no window");
    pulse_pin(TRP - 1);
    tick(1);
    eng_busy = 1'b0;
    expect_at(cyc + 1, 0, 1'b1, "R1 no recovery");
    tick(2);
    // valid reset during busy
    eng_busy = 1'b1;
    tick(2);
    a = cyc + 1;
    v = a + TRP - 1;
    expect_at(a, 2, 1'b0, "R3");
    expect_at(v - 1, 1, 1'b0, "R2");
    expect_at(v, 1, 1'b1, "R2");
    expect_at(v + 1, 1, 1'b0, "R2");
    for (int i = 0; i <= TB; i++) expect_at(v + i, 0, 1'b0, "R4");
    expect_at(v + TB + 1, 0, 1'b1, "R4");
    h = a + TRP + TB + 3;
    expect_at(h + TRH - 1, 2, 1'b0, "R6");
    expect_at(h + TRH, 2, 1'b1, "R6");
    pulse_pin(TRP + TB + 3);
    tick(TRH + 3);
    // valid reset while idle, write held across release
    oe_n = 1'b1; we_n = 1'b0;
    a = cyc + 1;
    v = a + TRP - 1;
    expect_at(a, 4, 1'b0, "R3");
    expect_at(v, 1, 1'b1, "R2");
    for (int i = 0; i <= TI; i++) expect_at(v + i, 0, 1'b0, "R5");
    expect_at(v + TI + 1, 0, 1'b1, "R5");
    h = a + TRP + TI + 3;
    expect_at(h + TRH - 1, 4, 1'b0, "R6");
    expect_at(h + TRH, 4, 1'b1, "R6");
    pulse_pin(TRP + TI + 3);
    tick(TRH + 3);
    // sleep entry with strobes toggling, then address exit
    we_n = 1'b1; oe_n = 1'b0; addr = 8'h55;
    c = cyc + 1;
    expect_at(c + TS - 1, 3, 1'b0, "R8");
    expect_at(c + TS, 3, 1'b1, "R8");
    expect_at(c + TS + 2, 3, 1'b1, "R8 stay");
    expect_at(c + TS + 1, 2, 1'b1, "R9 read in sleep");
    tick(2);
    ce_n = 1'b1; we_n = 1'b0;
    tick(1);
    oe_n = 1'b1;
    tick(1);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    while (cyc < c + TS + 3) tick(1);
    addr = 8'h56;
    expect_at(cyc + 1, 3, 1'b0, "R9");
    expect_at(cyc + 1, 2, 1'b1, "R9");
    tick(4);
    n_bad += exp_q.size();
    foreach (exp_q[i])
      $display("FAIL %s %s never compared expected=%b", exp_q[i].req,
               sname[exp_q[i].sig], exp_q[i].val);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule